// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one 16-step successive-approximation search per request. A conversion begins when the start input falls after being high. The block then raises a busy flag and emits a gated conversion clock that pulses a fixed number of times. On each pulse it drives a trial word to an external feedback DAC and takes back one keep/reject decision from an external comparator, working from the most significant bit down to the least. The register is in complementary form. A bit under trial or kept is driven low, and a word of all ones stands for a zero input.

When the last decision is made, the word is already on the output pins one clock before busy drops. A consumer can therefore treat the falling edge of busy as a data strobe. The result leaves as a plain parallel word with no valid/ready handshake. It cannot be back-pressured: it holds until the next conversion starts, so a consumer has the whole idle time to take it.

A format select picks complementary straight binary for unipolar ranges, complementary offset binary for bipolar ranges, or complementary two's complement. The select is captured when a conversion starts.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion is launched by the first clock edge that samples `start_in` low after it was sampled high while `busy` is low; `busy` reads 1 from the next clock onward.
- R2: After reset, and again on every launch, all register bits are in the off state (`dac_code` = 16'hFFFF); after reset `busy` and `conv_clk` are 0.
- R3: On the first conversion pulse the MSB is placed in trial (driven low) and bits 14..0 are held high (`dac_code` = 16'h7FFF). On each later pulse the bit under trial is kept low if the comparator sampled 1, or returned high if it sampled 0, and the next lower bit is driven low.
- R4: `conv_clk` makes exactly 17 pulses per conversion, each high for one clock and low for one clock, and stays 0 whenever `busy` is 0.
- R5: `busy` falls one clock after the rising edge of the 17th pulse. The final word is on `data_out` before that edge, and it is held unchanged until the next launch.
- R6: `cmp_in` is sampled on the clock that ends each pulse's high phase. With an ideal comparator (`cmp_in` = analog code >= ~`dac_code`), the final `dac_code` equals the bitwise complement of the analog code: code 0 gives 16'hFFFF, midscale 16'h8000 gives 16'h7FFF, and full scale 16'hFFFF gives 16'h0000.
- R7: A falling edge of `start_in` while `busy` is 1 is ignored. The running conversion still makes 17 pulses and gives the same result.
- R8: The `fmt_sel` encoding is 0 for straight binary and 1 for offset binary; both pass the register word unchanged. Encoding 2 selects two's complement, which inverts bit 15. Encoding 3 behaves as 1.
- R9: `fmt_sel` is captured at launch. A change while `busy` is 1 does not alter that conversion's `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Start request; its falling edge launches a conversion |
| fmt_sel | input | 2 | Output coding select, captured at launch |
| cmp_in | input | 1 | Comparator decision, 1 = keep the trial bit |
| conv_clk | output | 1 | Gated conversion clock, parked low when idle |
| busy | output | 1 | Conversion in progress; falling edge strobes the result |
| dac_code | output | 16 | Trial word to the feedback DAC (complementary) |
| data_out | output | 16 | Formatted result word |

## Verification
The hardest case to reach from the ports is a start edge that lands in the middle of a conversion, together with a format change during that conversion. A start that is merely ignored leaves no mark unless the bench checks that the pulse count, the busy timing and the result all match an undisturbed run. The bench drives both disturbances at fixed cycles inside selected conversions and compares against an arithmetic model. It also sweeps every format code over corner codes, walking-one and walking-zero patterns, and a pseudo-random set. For each of these it samples the trial word after the first two pulses and latches the output on the falling edge of busy.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    FMT_CSB = 2'd0,
    FMT_COB = 2'd1,
    FMT_CTC = 2'd2,
    FMT_ALT = 2'd3
  } out_fmt_e;
endpackage

// File: rtl/sar_start_det.sv
module sar_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  input  logic busy,
  output logic launch
);
  logic start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_in;
  end

  // trailing edge of the request, only when idle (R1, R7)
  assign launch = start_q & ~start_in & ~busy;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS = 16,
  localparam int NSTEPS = NBITS + 1,
  localparam int SW = $clog2(NSTEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  output logic          busy,
  output logic          conv_clk,
  output logic          step_en,
  output logic          sample_en,
  output logic [SW-1:0] step_idx
);
  localparam logic [SW-1:0] LAST = SW'(NSTEPS - 1);

  logic          phase_q;
  logic [SW-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      conv_clk <= 1'b0;
      phase_q  <= 1'b0;
      step_q   <= '0;
    end else if (launch) begin
      busy     <= 1'b1;
      conv_clk <= 1'b0;
      phase_q  <= 1'b0;
      step_q   <= '0;
    end else if (busy) begin
      if (!phase_q) begin
        conv_clk <= 1'b1;
        phase_q  <= 1'b1;
      end else begin
        conv_clk <= 1'b0;
        phase_q  <= 1'b0;
        if (step_q == LAST) busy <= 1'b0;
        else                step_q <= step_q + SW'(1);
      end
    end
  end

  assign step_en   = busy & ~phase_q;
  assign sample_en = busy & phase_q;
  assign step_idx  = step_q;

  // R4: clock parked low when idle
  p_clk_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_clk);
  // R4: step counter never passes the last pulse
  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step_q <= LAST);
  // R5: busy ends only after the high phase of the last pulse
  p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(step_q) == LAST && $past(phase_q)));
  // R7: busy only rises through a launch
  p_rise_by_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int NBITS = 16,
  localparam int NSTEPS = NBITS + 1,
  localparam int SW = $clog2(NSTEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step_en,
  input  logic             sample_en,
  input  logic [SW-1:0]    step_idx,
  input  logic             cmp_in,
  output logic [NBITS-1:0] sar
);
  logic cmp_q;

  // comparator registered at the end of each pulse's high phase (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmp_q <= 1'b0;
    else if (sample_en) cmp_q <= cmp_in;
  end

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    localparam logic [SW-1:0] TRY_STEP = SW'(NBITS - 1 - b);
    localparam logic [SW-1:0] DEC_STEP = SW'(NBITS - b);
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bit_q <= 1'b1;
      else if (init)                             bit_q <= 1'b1;
      else if (step_en && step_idx == TRY_STEP)  bit_q <= 1'b0;
      else if (step_en && step_idx == DEC_STEP)  bit_q <= ~cmp_q;
    end
    assign sar[b] = bit_q;
  end

  // R2: launch clears every bit to off
  p_init_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> sar == '1);
  // R3: first pulse puts only the MSB in trial
  p_msb_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_idx == '0) |=> sar == {1'b0, {(NBITS-1){1'b1}}});
  // R3: MSB decision follows the sampled comparator
  p_msb_decide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_idx == SW'(1)) |=> sar[NBITS-1] == !$past(cmp_q));
  // R5: word frozen outside steps and launches
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !step_en) |=> $stable(sar));
endmodule

// File: rtl/sar_fmt.sv
module sar_fmt
  import sar_pkg::*;
#(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             busy,
  input  logic [1:0]       fmt_sel,
  input  logic [NBITS-1:0] sar,
  output logic [NBITS-1:0] data_out
);
  out_fmt_e fmt_q;
  logic     flip_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fmt_q <= FMT_CSB;
    else if (launch) fmt_q <= out_fmt_e'(fmt_sel);
  end

  always_comb begin
    unique case (fmt_q)
      FMT_CTC: flip_msb = 1'b1;
      default: flip_msb = 1'b0;
    endcase
  end

  assign data_out = {sar[NBITS-1] ^ flip_msb, sar[NBITS-2:0]};

  // R9: format fixed for the whole conversion
  p_fmt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fmt_q));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_in,
  input  logic [1:0]       fmt_sel,
  input  logic             cmp_in,
  output logic             conv_clk,
  output logic             busy,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] data_out
);
  localparam int NSTEPS = NBITS + 1;
  localparam int SW = $clog2(NSTEPS);

  logic          launch;
  logic          step_en;
  logic          sample_en;
  logic [SW-1:0] step_idx;

  sar_start_det u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_in (start_in),
    .busy     (busy),
    .launch   (launch)
  );

  sar_seq #(.NBITS(NBITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .busy      (busy),
    .conv_clk  (conv_clk),
    .step_en   (step_en),
    .sample_en (sample_en),
    .step_idx  (step_idx)
  );

  sar_reg #(.NBITS(NBITS)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (launch),
    .step_en   (step_en),
    .sample_en (sample_en),
    .step_idx  (step_idx),
    .cmp_in    (cmp_in),
    .sar       (dac_code)
  );

  sar_fmt #(.NBITS(NBITS)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .busy     (busy),
    .fmt_sel  (fmt_sel),
    .sar      (dac_code),
    .data_out (data_out)
  );

  // R1: a launch always leads to busy on the next clock
  p_launch_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  // R5: result steady on the edge where busy drops
  p_strobe_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $stable(dac_code));
endmodule

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_in = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        cmp_in;
  logic        conv_clk;
  logic        busy;
  logic [15:0] dac_code;
  logic [15:0] data_out;
  logic [15:0] ana = 16'h0;
  logic [15:0] strobe_data = 16'h0;
  int          pulses = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  // ideal comparator: keep when the input is at or above the trial level
  assign cmp_in = (ana >= ~dac_code);

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .fmt_sel(fmt_sel),
    .cmp_in(cmp_in), .conv_clk(conv_clk), .busy(busy),
    .dac_code(dac_code), .data_out(data_out)
  );

  always @(posedge conv_clk) pulses = pulses + 1;
  always @(negedge busy) strobe_data = data_out;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [15:0] expect_word(input logic [15:0] a, input logic [1:0] f);
    logic [15:0] w;
    w = ~a;
    if (f == 2'd2) w[15] = ~w[15];
    return w;
  endfunction

  // disturb: 1 = spurious start during busy, 2 = format change during busy
  task automatic run_conv(input logic [15:0] a, input logic [1:0] f, input int disturb);
    int p0;
    logic [15:0] expv;
    logic [15:0] exp3;
    bit done;
    ana = a;
    fmt_sel = f;
    expv = expect_word(a, f);
    exp3 = 16'h3FFF | (a[15] ? 16'h0000 : 16'h8000);
    @(negedge clk); start_in = 1'b1;
    @(negedge clk);
    @(negedge clk); start_in = 1'b0;
    p0 = pulses;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after start fall", busy, 1);
    @(negedge clk);
    chk(dac_code == 16'h7FFF, "R3 first trial word", dac_code, 16'h7FFF);
    @(negedge clk);
    @(negedge clk);
    chk(dac_code == exp3, "R3 second trial word", dac_code, exp3);
    done = 0;
    for (int i = 0; i < 60 && !done; i++) begin
      @(negedge clk);
      if (disturb == 1 && i == 6)  start_in = 1'b1;
      if (disturb == 1 && i == 10) start_in = 1'b0;
      if (disturb == 2 && i == 8)  fmt_sel = ~f;
      if (!busy) done = 1;
    end
    chk(done, "R5 busy falls", done, 1);
    chk(pulses - p0 == 17, "R4 pulse count", pulses - p0, 17);
    chk(conv_clk == 1'b0, "R4 clock parked", conv_clk, 0);
    chk(data_out == expv, "R6 R8 result word", data_out, expv);
    chk(strobe_data == expv, "R5 word at busy fall", strobe_data, expv);
    if (disturb == 1) chk(busy == 1'b0, "R7 no restart", busy, 0);
    if (disturb == 2) chk(data_out == expv, "R9 format held", data_out, expv);
    fmt_sel = f ^ 2'd1;
    repeat (4) @(negedge clk);
    chk(pulses - p0 == 17, "R4 no idle pulses", pulses - p0, 17);
    chk(data_out == expv, "R5 result held idle", data_out, expv);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 reset busy", busy, 0);
    chk(conv_clk == 1'b0, "R2 reset clock", conv_clk, 0);
    chk(dac_code == 16'hFFFF, "R2 reset word", dac_code, 16'hFFFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R1 no launch without start", busy, 0);

    // R6 anchor points: zero, midscale, full scale
    run_conv(16'h0000, 2'd0, 0);
    run_conv(16'h8000, 2'd0, 0);
    run_conv(16'hFFFF, 2'd0, 0);
    run_conv(16'h7FFF, 2'd1, 0);
    run_conv(16'h0001, 2'd2, 0);

    lfsr = 16'hACE1;
    for (int f = 0; f < 4; f++) begin
      for (int b = 0; b < 16; b++) begin
        run_conv(16'h1 << b, 2'(f), 0);
        run_conv(~(16'h1 << b), 2'(f), 0);
      end
      for (int k = 0; k < 40; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        run_conv(lfsr, 2'(f), 0);
      end
    end

    // R7: spurious start edge mid-conversion
    run_conv(16'h5A3C, 2'd0, 1);
    run_conv(16'h8001, 2'd2, 1);
    // R9: format changed mid-conversion
    run_conv(16'h1234, 2'd2, 2);
    run_conv(16'hC0DE, 2'd0, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule